// File: doc/BRIEF.md
# Video Memory Block Transfer Engine

This engine moves data into the three video memories (pattern RAM, vertical scroll table, colour table) on behalf of a command decoder. It runs in two modes. In copy mode it fetches words one at a time from an external bus and writes each word to the selected memory. In fill mode it waits for one data-port write, stores that word normally, and then repeats the upper byte of the word across memory for a programmed number of steps.

Register writes set up the length, source and mode of a transfer, the address step and the enable bit. Both modes leave the length and source registers at the values they reached when the transfer ended, so a later transfer can carry on where the previous one stopped. The engine also owns the current write address, so ordinary data-port writes go through it as well. A data-port write that arrives while a copy is running is held back and applied after the copy, at the address the copy reached.

Top module: `vmem_dma_engine`

## Requirements
- R1: The word count comes from register 19 (bits 7:0) and register 20 (bits 15:8). A copy writes exactly that many words. A count of zero runs 65536 words.
- R2: `ext_addr` always presents the source word address. Register 21 sets bits 7:0, register 22 sets bits 15:8, and register 23 bits 6:0 set bits 22:16. The address rises by one for each word fetched.
- R3: Only source bits 15:0 count. Bits 22:16 never change during a transfer, so 0x03FFFF is followed by 0x030000.
- R4: Writing register 23 with bit 7 set selects fill mode and leaves the source address unchanged. Writing it with bit 7 clear selects copy mode.
- R5: A transfer command (`cmd_dma`=1) given while bit 4 of register 1 is 0 starts nothing: no fetch, no busy. It only sets the write address, as a plain command does.
- R6: A fill waits for a data-port write D. It writes D as a word at address A and moves A by the step. Then, once per count, it writes byte D[15:8] (`mem_byte`=1, shown on both halves of `mem_wdata`) at A XOR 1 and moves A by the step. It never fetches.
- R7: The length and source registers keep their advanced values after a transfer. A fill advances the source by its count. A later copy that reprograms only register 19 fetches from where the last transfer stopped.
- R8: A data-port write issued during a copy is written as a word after the last copied word, at the advanced address.
- R9: The write address moves by the step value held in register 15. It wraps to 16 bits for pattern RAM (target 0) and to 7 bits for the scroll table (target 1) and the colour table (target 2).
- R10: `busy` is 0 after reset. It is 1 from the cycle after a transfer command is accepted, including while a fill waits for data. It drops in the same cycle that the final write appears on the memory port.
- R11: A plain command (`cmd_dma`=0) sets the target and address. Each later data-port write is stored as a word (`mem_byte`=0) at that address, which then moves by the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register number |
| reg_wdata | input | 8 | Register write value |
| cmd_valid | input | 1 | Command strobe from the decoder |
| cmd_dma | input | 1 | Command requests a transfer |
| cmd_tgt | input | 2 | Target memory: 0 pattern, 1 scroll, 2 colour |
| cmd_addr | input | 16 | Start byte address |
| dp_we | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write value |
| ext_req | output | 1 | Fetch request to the external bus |
| ext_addr | output | 23 | Source word address |
| ext_ack | input | 1 | Fetch data valid this cycle |
| ext_rdata | input | 16 | Fetched word |
| mem_we | output | 1 | Memory write strobe |
| mem_tgt | output | 2 | Memory selected for the write |
| mem_addr | output | 16 | Write byte address |
| mem_wdata | output | 16 | Write data |
| mem_byte | output | 1 | Byte write of the lane picked by address bit 0 |
| busy | output | 1 | Transfer in progress |

## Verification
The bench follows the fill address sequence from both an even and an odd start. An engine that wrote the repeated byte at the address itself, or that skipped the step after the first word, would show the wrong addresses, for example 0x101 instead of 0x102. The bench runs a copy across the 64K source boundary and into the colour table past address 0x7E. A carry into bit 16 would show up on `ext_addr`, and a missing 7-bit wrap would produce a write at 0x80.

A zero-length copy must run all 65536 words, where a naive counter would stop at once. A data-port write queued during a copy must land after the last copied word and not in the middle of the copy. The bench also checks that the source and length registers carry over between transfers, and that a disabled transfer command only acts as an address setup.

// File: rtl/vde_pkg.sv
package vde_pkg;

  typedef enum logic [1:0] {
    TGT_PAT = 2'd0,
    TGT_VS  = 2'd1,
    TGT_COL = 2'd2,
    TGT_RSV = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COPY  = 2'd1,
    ST_FWAIT = 2'd2,
    ST_FILL  = 2'd3
  } st_e;

  // register numbers decoded by this engine
  localparam logic [4:0] RN_MODE2  = 5'd1;
  localparam logic [4:0] RN_STEP   = 5'd15;
  localparam logic [4:0] RN_CNT_LO = 5'd19;
  localparam logic [4:0] RN_CNT_HI = 5'd20;
  localparam logic [4:0] RN_SRC_LO = 5'd21;
  localparam logic [4:0] RN_SRC_MD = 5'd22;
  localparam logic [4:0] RN_SRC_HI = 5'd23;

  localparam int EN_BIT   = 4;
  localparam int FILL_BIT = 7;

endpackage

// File: rtl/vde_regs.sv
module vde_regs
  import vde_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SRC_W = 23,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [4:0]       reg_idx,
  input  logic [7:0]       reg_wdata,
  input  logic             step,
  output logic [LEN_W-1:0] len_q,
  output logic [SRC_W-1:0] src_q,
  output logic             fill_mode,
  output logic             dma_en,
  output logic [7:0]       inc_q
);

  localparam int HI_W = SRC_W - CNT_W;

  // only the low counting field advances; the upper field is frozen
  function automatic logic [SRC_W-1:0] src_next(input logic [SRC_W-1:0] s);
    src_next = {s[SRC_W-1:CNT_W], s[CNT_W-1:0] + CNT_W'(1)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q     <= '0;
      src_q     <= '0;
      fill_mode <= 1'b0;
      dma_en    <= 1'b0;
      inc_q     <= '0;
    end else begin
      if (step) begin
        len_q <= len_q - LEN_W'(1);
        src_q <= src_next(src_q);
      end
      if (reg_we) begin
        case (reg_idx)
          RN_MODE2:  dma_en <= reg_wdata[EN_BIT];
          RN_STEP:   inc_q <= reg_wdata;
          RN_CNT_LO: len_q[7:0] <= reg_wdata;
          RN_CNT_HI: len_q[LEN_W-1:8] <= reg_wdata[LEN_W-9:0];
          RN_SRC_LO: src_q[7:0] <= reg_wdata;
          RN_SRC_MD: src_q[15:8] <= reg_wdata;
          RN_SRC_HI: begin
            fill_mode <= reg_wdata[FILL_BIT];
            if (!reg_wdata[FILL_BIT])
              src_q[SRC_W-1:CNT_W] <= reg_wdata[HI_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/vde_ctrl.sv
module vde_ctrl
  import vde_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int LEN_W  = 16,
  parameter int VS_AW  = 7,
  parameter int COL_AW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_dma,
  input  logic [1:0]       cmd_tgt,
  input  logic [AW-1:0]    cmd_addr,
  input  logic             dp_we,
  input  logic [DW-1:0]    dp_wdata,
  input  logic             ext_ack,
  input  logic [DW-1:0]    ext_rdata,
  input  logic [LEN_W-1:0] len_q,
  input  logic             dma_en,
  input  logic             fill_mode,
  input  logic [7:0]       inc_q,
  output logic             ext_req,
  output logic             step,
  output logic             wr_v,
  output logic             wr_byte,
  output logic [1:0]       wr_tgt,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             busy,
  output logic             fill_wait
);

  localparam logic [AW-1:0] VS_MASK  = AW'((1 << VS_AW) - 1);
  localparam logic [AW-1:0] COL_MASK = AW'((1 << COL_AW) - 1);
  localparam int            HB       = DW / 2;

  function automatic logic [AW-1:0] wrap_addr(input logic [AW-1:0] a, input tgt_e t);
    case (t)
      TGT_VS:  wrap_addr = a & VS_MASK;
      TGT_COL: wrap_addr = a & COL_MASK;
      default: wrap_addr = a;
    endcase
  endfunction

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a, input logic [7:0] inc,
                                              input tgt_e t);
    addr_next = wrap_addr(a + AW'(inc), t);
  endfunction

  st_e            st_q, st_d;
  tgt_e           tgt_q, tgt_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           pend_v;
  logic [DW-1:0]  pend_d, fill_d;
  logic           consume;
  logic           last;

  assign last      = (len_q == LEN_W'(1));
  assign busy      = (st_q != ST_IDLE);
  assign fill_wait = (st_q == ST_FWAIT);
  assign wr_tgt    = tgt_q;

  always_comb begin
    st_d    = st_q;
    tgt_d   = tgt_q;
    addr_d  = addr_q;
    consume = 1'b0;
    ext_req = 1'b0;
    step    = 1'b0;
    wr_v    = 1'b0;
    wr_byte = 1'b0;
    wr_addr = addr_q;
    wr_data = pend_d;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          tgt_d  = tgt_e'(cmd_tgt);
          addr_d = wrap_addr(cmd_addr, tgt_e'(cmd_tgt));
          if (cmd_dma && dma_en)
            st_d = fill_mode ? ST_FWAIT : ST_COPY;
        end else if (pend_v) begin
          consume = 1'b1;
          wr_v    = 1'b1;
          addr_d  = addr_next(addr_q, inc_q, tgt_q);
        end
      end
      ST_FWAIT: begin
        if (pend_v) begin
          consume = 1'b1;
          wr_v    = 1'b1;
          addr_d  = addr_next(addr_q, inc_q, tgt_q);
          st_d    = ST_FILL;
        end
      end
      ST_FILL: begin
        wr_v    = 1'b1;
        wr_byte = 1'b1;
        wr_addr = addr_q ^ AW'(1);
        wr_data = {fill_d[DW-1:HB], fill_d[DW-1:HB]};
        step    = 1'b1;
        addr_d  = addr_next(addr_q, inc_q, tgt_q);
        if (last) st_d = ST_IDLE;
      end
      ST_COPY: begin
        ext_req = 1'b1;
        if (ext_ack) begin
          wr_v    = 1'b1;
          wr_data = ext_rdata;
          step    = 1'b1;
          addr_d  = addr_next(addr_q, inc_q, tgt_q);
          if (last) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= TGT_PAT;
      addr_q <= '0;
      pend_v <= 1'b0;
      pend_d <= '0;
      fill_d <= '0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      addr_q <= addr_d;
      if (dp_we) begin
        pend_v <= 1'b1;
        pend_d <= dp_wdata;
      end else if (consume) begin
        pend_v <= 1'b0;
      end
      if (consume && st_q == ST_FWAIT)
        fill_d <= pend_d;
    end
  end

endmodule

// File: rtl/vde_wport.sv
module vde_wport #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_v,
  input  logic          wr_byte,
  input  logic [1:0]    wr_tgt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [1:0]    mem_tgt,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_byte  <= 1'b0;
      mem_tgt   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr_v;
      if (wr_v) begin
        mem_byte  <= wr_byte;
        mem_tgt   <= wr_tgt;
        mem_addr  <= wr_addr;
        mem_wdata <= wr_data;
      end
    end
  end

endmodule

// File: rtl/vmem_dma_engine.sv
module vmem_dma_engine #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int LEN_W  = 16,
  parameter int SRC_W  = 23,
  parameter int CNT_W  = 16,
  parameter int VS_AW  = 7,
  parameter int COL_AW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [4:0]       reg_idx,
  input  logic [7:0]       reg_wdata,
  input  logic             cmd_valid,
  input  logic             cmd_dma,
  input  logic [1:0]       cmd_tgt,
  input  logic [AW-1:0]    cmd_addr,
  input  logic             dp_we,
  input  logic [DW-1:0]    dp_wdata,
  output logic             ext_req,
  output logic [SRC_W-1:0] ext_addr,
  input  logic             ext_ack,
  input  logic [DW-1:0]    ext_rdata,
  output logic             mem_we,
  output logic [1:0]       mem_tgt,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_byte,
  output logic             busy
);

  logic [LEN_W-1:0] len_q;
  logic [SRC_W-1:0] src_q;
  logic             fill_mode, dma_en, step;
  logic [7:0]       inc_q;
  logic             wr_v, wr_byte, fill_wait;
  logic [1:0]       wr_tgt;
  logic [AW-1:0]    wr_addr;
  logic [DW-1:0]    wr_data;

  assign ext_addr = src_q;

  vde_regs #(.LEN_W(LEN_W), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .step(step), .len_q(len_q), .src_q(src_q),
    .fill_mode(fill_mode), .dma_en(dma_en), .inc_q(inc_q)
  );

  vde_ctrl #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .VS_AW(VS_AW), .COL_AW(COL_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dma(cmd_dma),
    .cmd_tgt(cmd_tgt), .cmd_addr(cmd_addr), .dp_we(dp_we), .dp_wdata(dp_wdata),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata), .len_q(len_q), .dma_en(dma_en),
    .fill_mode(fill_mode), .inc_q(inc_q), .ext_req(ext_req), .step(step),
    .wr_v(wr_v), .wr_byte(wr_byte), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .fill_wait(fill_wait)
  );

  vde_wport #(.AW(AW), .DW(DW)) u_wport (
    .clk(clk), .rst_n(rst_n), .wr_v(wr_v), .wr_byte(wr_byte), .wr_tgt(wr_tgt),
    .wr_addr(wr_addr), .wr_data(wr_data), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_tgt(mem_tgt), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/vde_checker.sv
module vde_checker #(
  parameter int SRC_W = 23,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ext_req,
  input logic             ext_ack,
  input logic [SRC_W-1:0] ext_addr,
  input logic             mem_we,
  input logic             mem_byte,
  input logic [DW-1:0]    mem_wdata,
  input logic             cmd_valid,
  input logic             cmd_dma,
  input logic             dma_en,
  input logic             reg_we,
  input logic             fill_wait
);

  AST_FETCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> busy); // R10

  AST_SRC_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack && !reg_we) |=>
      (ext_addr[15:0] == $past(ext_addr[15:0]) + 16'd1) &&
      (ext_addr[SRC_W-1:16] == $past(ext_addr[SRC_W-1:16]))); // R3

  AST_FETCH_GIVES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (mem_we && !mem_byte)); // R9

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_dma && !dma_en && !busy) |=> !busy); // R5

  AST_BUSY_END_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> mem_we); // R10

  AST_FILL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wait |-> (!ext_req && busy)); // R6

  AST_FILL_BYTE_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_byte) |-> (mem_wdata[DW-1:DW/2] == mem_wdata[DW/2-1:0])); // R6

endmodule

bind vmem_dma_engine vde_checker #(.SRC_W(SRC_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ext_req(ext_req), .ext_ack(ext_ack),
  .ext_addr(ext_addr), .mem_we(mem_we), .mem_byte(mem_byte), .mem_wdata(mem_wdata),
  .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .dma_en(dma_en), .reg_we(reg_we),
  .fill_wait(fill_wait)
);

// File: tb/tb_vmem_dma_engine.sv
module tb_vmem_dma_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_wdata;
  logic        cmd_valid, cmd_dma;
  logic [1:0]  cmd_tgt;
  logic [15:0] cmd_addr;
  logic        dp_we;
  logic [15:0] dp_wdata;
  logic        ext_req, ext_ack;
  logic [22:0] ext_addr;
  logic [15:0] ext_rdata;
  logic        mem_we, mem_byte, busy;
  logic [1:0]  mem_tgt;
  logic [15:0] mem_addr, mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] src_word(input logic [22:0] a);
    return a[15:0] ^ {a[22:16], 9'h155};
  endfunction

  assign ext_ack   = ext_req;
  assign ext_rdata = src_word(ext_addr);

  vmem_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_tgt(cmd_tgt), .cmd_addr(cmd_addr),
    .dp_we(dp_we), .dp_wdata(dp_wdata), .ext_req(ext_req), .ext_addr(ext_addr),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata), .mem_we(mem_we), .mem_tgt(mem_tgt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_byte(mem_byte), .busy(busy)
  );

  typedef struct {
    logic [1:0]  t;
    logic [15:0] a;
    logic [15:0] d;
    logic        b;
    string       r;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   req_cycles = 0;
  logic [22:0] m_src;
  logic [15:0] m_addr;
  logic [7:0]  m_inc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (ext_req) req_cycles++;
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 unexpected write: actual %h@%h expected none", mem_wdata, mem_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(mem_tgt == e.t && mem_addr == e.a && mem_wdata == e.d && mem_byte == e.b,
              e.r, "memory write {tgt,byte,addr,data}",
              {1'b0, mem_tgt, mem_byte, mem_addr[11:0], mem_wdata},
              {1'b0, e.t, e.b, e.a[11:0], e.d});
      end
    end
  end

  function automatic logic [15:0] bwrap(input logic [15:0] a, input logic [1:0] t);
    return (t == 2'd1 || t == 2'd2) ? (a % 16'd128) : a;
  endfunction

  task automatic push(input logic [1:0] t, input logic [15:0] a, input logic [15:0] d,
                      input logic b, input string r);
    exp_t e;
    e.t = t; e.a = a; e.d = d; e.b = b; e.r = r;
    exp_q.push_back(e);
  endtask

  // expected copy: n words from m_src to m_addr
  task automatic push_copy(input logic [1:0] t, input int n, input string r);
    for (int i = 0; i < n; i++) begin
      push(t, m_addr, src_word(m_src), 1'b0, r);
      m_addr = bwrap(m_addr + {8'h00, m_inc}, t);
      m_src  = {m_src[22:16], m_src[15:0] + 16'd1};
    end
  endtask

  task automatic reg_wr(input logic [4:0] idx, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    if (idx == 5'd15) m_inc = v;
  endtask

  task automatic command(input logic dma, input logic [1:0] t, input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dma = dma; cmd_tgt = t; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_dma = 1'b0;
    m_addr = bwrap(a, t);
  endtask

  task automatic dp_write(input logic [15:0] d);
    dp_we = 1'b1; dp_wdata = d;
    @(negedge clk);
    dp_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual busy=%b expected run to finish", busy);
    summary();
    $finish;
  end

  initial begin
    int rc;
    rst_n = 1'b0; reg_we = 0; reg_idx = 0; reg_wdata = 0;
    cmd_valid = 0; cmd_dma = 0; cmd_tgt = 0; cmd_addr = 0;
    dp_we = 0; dp_wdata = 0; m_src = '0; m_addr = '0; m_inc = 8'h00;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(busy == 1'b0, "R10", "busy after reset", {31'd0, busy}, 0);
    check(ext_req == 1'b0 && mem_we == 1'b0, "R10", "req/we after reset",
          {30'd0, ext_req, mem_we}, 0);
    rst_n = 1'b1;

    // R11 plain writes
    reg_wr(5'd15, 8'd2);
    command(1'b0, 2'd0, 16'h0040);
    push(2'd0, 16'h0040, 16'hABCD, 1'b0, "R11");
    push(2'd0, 16'h0042, 16'h1234, 1'b0, "R11");
    dp_write(16'hABCD); repeat (2) @(negedge clk);
    dp_write(16'h1234); wait_idle();

    // R1 R2 R9 copy of 4 words
    reg_wr(5'd1, 8'h10);
    reg_wr(5'd19, 8'd4); reg_wr(5'd20, 8'd0);
    reg_wr(5'd21, 8'h10); reg_wr(5'd22, 8'h20); reg_wr(5'd23, 8'h05);
    check(ext_addr == 23'h052010, "R2", "source from regs 21-23", {9'd0, ext_addr}, 32'h052010);
    m_src = 23'h052010;
    command(1'b1, 2'd0, 16'h0100);
    check(busy == 1'b1, "R10", "busy during copy", {31'd0, busy}, 1);
    push_copy(2'd0, 4, "R1");
    wait_idle();
    check(ext_addr == 23'h052014, "R2", "source after copy", {9'd0, ext_addr}, 32'h052014);

    // R7 only low length byte reprogrammed
    reg_wr(5'd19, 8'd2);
    command(1'b1, 2'd0, 16'h0200);
    push_copy(2'd0, 2, "R7");
    wait_idle();

    // R3 source wrap, R9 colour wrap
    reg_wr(5'd21, 8'hFF); reg_wr(5'd22, 8'hFF); reg_wr(5'd23, 8'h03);
    m_src = 23'h03FFFF;
    reg_wr(5'd19, 8'd3);
    command(1'b1, 2'd2, 16'h007C);
    push_copy(2'd2, 3, "R9");
    wait_idle();
    check(ext_addr == 23'h030002, "R3", "source low wrap", {9'd0, ext_addr}, 32'h030002);

    // R8 data write queued during copy
    reg_wr(5'd19, 8'd2);
    command(1'b1, 2'd0, 16'h0300);
    push_copy(2'd0, 2, "R8");
    push(2'd0, 16'h0304, 16'h5EC8, 1'b0, "R8");
    dp_write(16'h5EC8);
    wait_idle();

    // R4 fill select leaves source alone; R6 even fill
    reg_wr(5'd15, 8'd3);
    reg_wr(5'd19, 8'd3);
    reg_wr(5'd23, 8'h85);
    check(ext_addr == 23'h030004, "R4", "source after fill select", {9'd0, ext_addr}, 32'h030004);
    command(1'b1, 2'd0, 16'h0100);
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && ext_req == 1'b0, "R6", "waiting fill busy, no fetch",
          {30'd0, busy, ext_req}, 32'd2);
    push(2'd0, 16'h0100, 16'h1122, 1'b0, "R6");
    push(2'd0, 16'h0102, 16'h1111, 1'b1, "R6");
    push(2'd0, 16'h0107, 16'h1111, 1'b1, "R6");
    push(2'd0, 16'h0108, 16'h1111, 1'b1, "R6");
    dp_write(16'h1122);
    wait_idle();
    check(ext_addr == 23'h030007, "R7", "fill advances source", {9'd0, ext_addr}, 32'h030007);

    // R6 odd fill start
    reg_wr(5'd19, 8'd3);
    command(1'b1, 2'd0, 16'h0101);
    push(2'd0, 16'h0101, 16'h1122, 1'b0, "R6");
    push(2'd0, 16'h0105, 16'h1111, 1'b1, "R6");
    push(2'd0, 16'h0106, 16'h1111, 1'b1, "R6");
    push(2'd0, 16'h010B, 16'h1111, 1'b1, "R6");
    dp_write(16'h1122);
    wait_idle();

    // R7 copy after fill continues source
    reg_wr(5'd23, 8'h03);
    reg_wr(5'd15, 8'd2);
    reg_wr(5'd19, 8'd1);
    m_src = 23'h03000A;
    command(1'b1, 2'd0, 16'h0400);
    push_copy(2'd0, 1, "R7");
    wait_idle();

    // R5 disabled transfer is address setup only
    reg_wr(5'd1, 8'h00);
    reg_wr(5'd19, 8'd2);
    rc = req_cycles;
    command(1'b1, 2'd0, 16'h0500);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R5", "busy with enable clear", {31'd0, busy}, 0);
    push(2'd0, 16'h0500, 16'h7777, 1'b0, "R5");
    dp_write(16'h7777);
    wait_idle();
    check(req_cycles == rc, "R5", "fetch cycles while disabled", req_cycles, rc);
    reg_wr(5'd1, 8'h10);

    // R1 zero length = 65536 words, R3 full wrap
    reg_wr(5'd19, 8'd0); reg_wr(5'd20, 8'd0);
    reg_wr(5'd21, 8'h00); reg_wr(5'd22, 8'h00); reg_wr(5'd23, 8'h02);
    m_src = 23'h020000;
    rc = req_cycles;
    command(1'b1, 2'd0, 16'h0000);
    push_copy(2'd0, 65536, "R1");
    wait_idle();
    check(req_cycles - rc == 65536, "R1", "words fetched for zero length",
          req_cycles - rc, 65536);
    check(ext_addr == 23'h020000, "R3", "source after full wrap", {9'd0, ext_addr}, 32'h020000);

    check(exp_q.size() == 0, "R6", "expected writes left over", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule